// File: doc/BRIEF.md
# Lane-Aware Dynamic Warp Former

This block sits behind the last stage of a SIMD pipeline. Each cycle it may take one retiring thread, given as a thread ID and the program counter that thread runs next, and places it into a warp with other threads bound for the same program counter. A thread is only ever placed in its home lane, the thread ID taken modulo the lane count. Because of this rule the register file banks never need a crossbar. A small table keeps one forming warp per live program counter, with an occupancy vector of taken lanes. When a thread's lane is already taken, the forming warp is closed and a fresh warp is opened for that PC, holding the new thread.

The scheduler asks for a warp by raising `issue_req`. The block then picks the PC with the most pending warps, with ties going to the lower PC. It keeps issuing warps at that PC until none are left, and only then picks again. Within one PC, closed warps go out before the warp still forming, so the table entry is released when the last warp at that PC leaves. The input stalls through `in_ready` when no table entry or warp slot is available. It also stalls when the thread's forming warp is being issued in that same cycle.

Top module: `warp_packer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1, and the block holds no pending warp.
- R2: A thread's home lane is `in_tid % LANES`. In the issued warp its ID appears in `out_tids[lane*TID_W +: TID_W]` and bit `lane` of `out_mask` is 1.
- R3: A thread whose PC already has a forming warp with its home lane free joins that warp, and no new warp is created.
- R4: A thread whose home lane is already taken in its PC's forming warp closes that warp and opens a new one at the same PC that holds only this thread.
- R5: The table never holds two live entries for the same PC.
- R6: A thread with a PC that has no table entry is refused (`in_ready` 0) while all NENT entries are live.
- R7: A thread that needs a new warp is refused while all NWARP warp slots are pending.
- R8: When no PC is being drained, the issued PC is the one with the most pending warps, counting forming and closed warps. Ties go to the numerically lowest PC.
- R9: Once a PC is issued, each later issue takes that PC for as long as warps at it remain pending.
- R10: At one PC, every closed warp issues before the forming warp. Issuing the forming warp frees its table entry.
- R11: A thread is refused while the forming warp for its PC is being issued in the same cycle.
- R12: `out_valid` is 1 in the cycle after an `issue_req` cycle that finds a pending warp, and 0 otherwise. An issued warp has a nonzero mask, and its unused lanes carry thread ID 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A retiring thread is offered |
| in_ready | output | 1 | The offered thread is taken this cycle |
| in_tid | input | TID_W | Thread ID |
| in_pc | input | PC_W | Next program counter of the thread |
| issue_req | input | 1 | Scheduler asks for one warp this cycle |
| out_valid | output | 1 | A warp is presented this cycle |
| out_pc | output | PC_W | PC of the presented warp |
| out_tids | output | LANES*TID_W | Thread ID per lane, lane 0 in the low bits |
| out_mask | output | LANES | Lanes holding a thread |

## Verification
Most faults in the lookup table or the lane occupancy become visible at the ports within a few cycles. A bad occupancy vector either drops a thread's ID from an issued warp or splits one warp into two. A stale or duplicated table entry changes `in_ready` the next time that PC arrives. A wrong pending count or a lost drain lock shows up as a wrong `out_pc` on the very next issue. A forming flag that is cleared at the wrong time shows up as the forming warp leaving before a closed warp at the same PC. It also shows up as a table entry that stays live or is freed early, which the next thread at that PC exposes through `in_ready`.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // home lane of a thread: its ID folded onto the lane count
  function automatic int unsigned lane_of(input int unsigned tid, input int unsigned lanes);
    return tid % lanes;
  endfunction

  // true when candidate A should win over B in the popularity race
  function automatic bit outranks(input int unsigned cnt_a, input int unsigned pc_a,
                                  input int unsigned cnt_b, input int unsigned pc_b);
    return (cnt_a > cnt_b) || ((cnt_a == cnt_b) && (pc_a < pc_b));
  endfunction

endpackage

// File: rtl/wp_pc_table.sv
module wp_pc_table #(
  parameter int NENT  = 8,
  parameter int PC_W  = 16,
  parameter int SW    = 4,
  parameter int LANES = 8,
  localparam int IW   = $clog2(NENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  look_pc,
  output logic             hit,
  output logic [IW-1:0]    hit_idx,
  output logic [SW-1:0]    hit_slot,
  output logic [LANES-1:0] hit_occ,
  output logic             free_any,
  output logic [IW-1:0]    free_idx,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [SW-1:0]    wr_slot,
  input  logic [LANES-1:0] wr_occ,
  input  logic             clr_en,
  input  logic [PC_W-1:0]  clr_pc
);
  logic [NENT-1:0]  e_vld;
  logic [PC_W-1:0]  e_pc   [NENT];
  logic [SW-1:0]    e_slot [NENT];
  logic [LANES-1:0] e_occ  [NENT];
  logic [NENT-1:0]  match;

  always_comb begin
    hit = 1'b0; hit_idx = '0; hit_slot = '0; hit_occ = '0;
    free_any = 1'b0; free_idx = '0;
    for (int i = 0; i < NENT; i++) begin
      match[i] = e_vld[i] && (e_pc[i] == look_pc);
      if (match[i] && !hit) begin
        hit = 1'b1; hit_idx = IW'(i); hit_slot = e_slot[i]; hit_occ = e_occ[i];
      end
      if (!e_vld[i] && !free_any) begin
        free_any = 1'b1; free_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld <= '0;
      for (int i = 0; i < NENT; i++) begin
        e_pc[i] <= '0; e_slot[i] <= '0; e_occ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NENT; i++)
        if (clr_en && e_vld[i] && (e_pc[i] == clr_pc)) e_vld[i] <= 1'b0;
      if (wr_en) begin
        e_vld[wr_idx]  <= 1'b1;
        e_pc[wr_idx]   <= wr_pc;
        e_slot[wr_idx] <= wr_slot;
        e_occ[wr_idx]  <= wr_occ;
      end
    end
  end

  // R5: one live entry per PC at most
  p_unique_pc_r5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));

endmodule

// File: rtl/wp_issue_pick.sv
module wp_issue_pick #(
  parameter int NWARP = 16,
  parameter int PC_W  = 16,
  localparam int SW   = $clog2(NWARP),
  localparam int CW   = $clog2(NWARP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NWARP-1:0] busy,
  input  logic [NWARP-1:0] frm,
  input  logic [PC_W-1:0]  pcs [NWARP],
  input  logic [PC_W-1:0]  cur_pc,
  input  logic             cur_vld,
  output logic             any,
  output logic [PC_W-1:0]  sel_pc,
  output logic [SW-1:0]    sel_slot,
  output logic             sel_frm
);
  logic [CW-1:0]   cnt [NWARP];
  logic [CW-1:0]   best_cnt;
  logic [PC_W-1:0] best_pc;
  logic            lock_hit, found;

  always_comb begin
    best_cnt = '0; best_pc = '0; lock_hit = 1'b0;
    for (int i = 0; i < NWARP; i++) begin
      cnt[i] = '0;
      for (int j = 0; j < NWARP; j++)
        if (busy[j] && (pcs[j] == pcs[i])) cnt[i] = cnt[i] + 1'b1;
    end
    for (int i = 0; i < NWARP; i++) begin
      if (busy[i] && ((best_cnt == '0) ||
          wp_pkg::outranks(int'(cnt[i]), int'(pcs[i]), int'(best_cnt), int'(best_pc)))) begin
        best_cnt = cnt[i]; best_pc = pcs[i];
      end
      if (busy[i] && cur_vld && (pcs[i] == cur_pc)) lock_hit = 1'b1;
    end
    any    = |busy;
    sel_pc = lock_hit ? cur_pc : best_pc;
    found = 1'b0; sel_slot = '0; sel_frm = 1'b0;
    for (int i = 0; i < NWARP; i++)
      if (!found && busy[i] && !frm[i] && (pcs[i] == sel_pc)) begin
        found = 1'b1; sel_slot = SW'(i);
      end
    for (int i = 0; i < NWARP; i++)
      if (!found && busy[i] && (pcs[i] == sel_pc)) begin
        found = 1'b1; sel_slot = SW'(i); sel_frm = frm[i];
      end
  end

  // R8: the chosen slot is pending and carries the chosen PC
  p_sel_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (busy[sel_slot] && (pcs[sel_slot] == sel_pc)));
  // R10: a forming warp is picked only when it is the last one at its PC
  p_form_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (any && sel_frm) |-> (cnt[sel_slot] == CW'(1)));

endmodule

// File: rtl/warp_packer.sv
module warp_packer #(
  parameter int LANES = 8,
  parameter int NENT  = 8,
  parameter int NWARP = 16,
  parameter int TID_W = 8,
  parameter int PC_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [TID_W-1:0]       in_tid,
  input  logic [PC_W-1:0]        in_pc,
  input  logic                   issue_req,
  output logic                   out_valid,
  output logic [PC_W-1:0]        out_pc,
  output logic [LANES*TID_W-1:0] out_tids,
  output logic [LANES-1:0]       out_mask
);
  localparam int LW = $clog2(LANES);
  localparam int SW = $clog2(NWARP);
  localparam int IW = $clog2(NENT);

  // warp slot pool
  logic [NWARP-1:0] s_busy, s_frm;
  logic [PC_W-1:0]  s_pc   [NWARP];
  logic [TID_W-1:0] s_tid  [NWARP][LANES];
  logic [LANES-1:0] s_mask [NWARP];
  logic [PC_W-1:0]  cur_pc;
  logic             cur_vld;

  // named internal events
  logic             hit, ent_free, slot_free, conflict, need_slot, clash, acc, issue_fire;
  logic [IW-1:0]    hit_idx, free_idx;
  logic [SW-1:0]    hit_slot, free_slot, sel_slot;
  logic [LANES-1:0] hit_occ, lane_bit;
  logic [LW-1:0]    lane;
  logic             any, sel_frm;
  logic [PC_W-1:0]  sel_pc;

  wp_pc_table #(.NENT(NENT), .PC_W(PC_W), .SW(SW), .LANES(LANES)) table_i (
    .clk(clk), .rst_n(rst_n), .look_pc(in_pc),
    .hit(hit), .hit_idx(hit_idx), .hit_slot(hit_slot), .hit_occ(hit_occ),
    .free_any(ent_free), .free_idx(free_idx),
    .wr_en(acc), .wr_idx(hit ? hit_idx : free_idx), .wr_pc(in_pc),
    .wr_slot(need_slot ? free_slot : hit_slot),
    .wr_occ(need_slot ? lane_bit : (hit_occ | lane_bit)),
    .clr_en(issue_fire && sel_frm), .clr_pc(sel_pc));

  wp_issue_pick #(.NWARP(NWARP), .PC_W(PC_W)) pick_i (
    .clk(clk), .rst_n(rst_n), .busy(s_busy), .frm(s_frm), .pcs(s_pc),
    .cur_pc(cur_pc), .cur_vld(cur_vld),
    .any(any), .sel_pc(sel_pc), .sel_slot(sel_slot), .sel_frm(sel_frm));

  always_comb begin
    lane      = LW'(wp_pkg::lane_of(int'(in_tid), LANES));
    lane_bit  = LANES'(1) << lane;
    slot_free = 1'b0; free_slot = '0;
    for (int i = 0; i < NWARP; i++)
      if (!s_busy[i] && !slot_free) begin
        slot_free = 1'b1; free_slot = SW'(i);
      end
    conflict   = hit && ((hit_occ & lane_bit) != '0);
    need_slot  = !hit || conflict;
    issue_fire = issue_req && any;
    clash      = hit && issue_fire && (sel_slot == hit_slot);
    in_ready   = !clash && (!need_slot || slot_free) && (hit || ent_free);
    acc        = in_valid && in_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_busy <= '0; s_frm <= '0;
      for (int i = 0; i < NWARP; i++) begin
        s_pc[i] <= '0; s_mask[i] <= '0;
        for (int l = 0; l < LANES; l++) s_tid[i][l] <= '0;
      end
      cur_pc <= '0; cur_vld <= 1'b0;
      out_valid <= 1'b0; out_pc <= '0; out_tids <= '0; out_mask <= '0;
    end else begin
      out_valid <= issue_fire;
      if (issue_fire) begin
        s_busy[sel_slot] <= 1'b0;
        s_frm[sel_slot]  <= 1'b0;
        out_pc   <= sel_pc;
        out_mask <= s_mask[sel_slot];
        for (int l = 0; l < LANES; l++) out_tids[l*TID_W +: TID_W] <= s_tid[sel_slot][l];
        cur_pc  <= sel_pc;
        cur_vld <= 1'b1;
      end
      if (acc) begin
        if (!need_slot) begin
          s_tid[hit_slot][lane] <= in_tid;
          s_mask[hit_slot]      <= s_mask[hit_slot] | lane_bit;
        end else begin
          s_busy[free_slot] <= 1'b1;
          s_frm[free_slot]  <= 1'b1;
          s_pc[free_slot]   <= in_pc;
          s_mask[free_slot] <= lane_bit;
          for (int l = 0; l < LANES; l++)
            s_tid[free_slot][l] <= (LW'(l) == lane) ? in_tid : '0;
          if (hit) s_frm[hit_slot] <= 1'b0;
        end
      end
    end
  end

  // R3: the table's occupancy vector tracks the lanes filled in its warp
  p_occ_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (s_mask[hit_slot] == hit_occ));
  // R12: a granted request is presented on the next cycle
  p_fire_out_r12: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> out_valid);
  // R12: a presented warp carries at least one thread
  p_out_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask != '0));
  // R4: after a lane conflict the table still maps the PC to a one-lane warp
  p_conflict_new_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && conflict) |=> $countones(s_mask[$past(free_slot)]) == 1);

endmodule

// File: tb/warp_packer_tb_top.sv
`timescale 1ns/1ps
module warp_packer_tb_top;
  localparam int LANES = 8, NENT = 8, NWARP = 16, TID_W = 8, PC_W = 16, MW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, issue_req = 1'b0;
  logic [TID_W-1:0] in_tid = '0;
  logic [PC_W-1:0]  in_pc = '0;
  logic in_ready, out_valid;
  logic [PC_W-1:0] out_pc;
  logic [LANES*TID_W-1:0] out_tids;
  logic [LANES-1:0] out_mask;

  warp_packer #(.LANES(LANES), .NENT(NENT), .NWARP(NWARP), .TID_W(TID_W), .PC_W(PC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_tid(in_tid),
    .in_pc(in_pc), .issue_req(issue_req), .out_valid(out_valid), .out_pc(out_pc),
    .out_tids(out_tids), .out_mask(out_mask));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model of pending warps
  bit              m_vld [MW];
  bit              m_form[MW];
  int unsigned     m_pc  [MW];
  logic [LANES-1:0] m_mask[MW];
  logic [TID_W-1:0] m_tid [MW][LANES];
  bit              m_lock_v = 1'b0;
  int unsigned     m_lock_pc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int n_warps();
    int n = 0;
    for (int i = 0; i < MW; i++) if (m_vld[i]) n++;
    return n;
  endfunction

  function automatic int pc_count(input int unsigned pc);
    int n = 0;
    for (int i = 0; i < MW; i++) if (m_vld[i] && m_pc[i] == pc) n++;
    return n;
  endfunction

  function automatic int forming_of(input int unsigned pc);
    for (int i = 0; i < MW; i++) if (m_vld[i] && m_form[i] && m_pc[i] == pc) return i;
    return -1;
  endfunction

  function automatic int n_entries();
    int n = 0;
    for (int i = 0; i < MW; i++) if (m_vld[i] && m_form[i]) n++;
    return n;
  endfunction

  function automatic int unsigned popular_pc();
    int best = 0; int unsigned bpc = 0;
    for (int i = 0; i < MW; i++)
      if (m_vld[i]) begin
        int c = pc_count(m_pc[i]);
        if (c > best || (c == best && m_pc[i] < bpc)) begin best = c; bpc = m_pc[i]; end
      end
    return bpc;
  endfunction

  task automatic send(input int unsigned tid, input int unsigned pc);
    int lane, f, slot;
    bit exp_rdy; string tag;
    @(negedge clk);
    in_valid = 1'b1; in_tid = TID_W'(tid); in_pc = PC_W'(pc);
    #1;
    lane = int'(tid & (LANES - 1));
    f = forming_of(pc);
    if (f >= 0 && !m_mask[f][lane]) begin exp_rdy = 1'b1; tag = "R3"; end
    else if (n_warps() >= NWARP) begin exp_rdy = 1'b0; tag = "R7"; end
    else if (f < 0 && n_entries() >= NENT) begin exp_rdy = 1'b0; tag = "R6"; end
    else begin exp_rdy = 1'b1; tag = (f >= 0) ? "R4" : "R5"; end
    chk(in_ready == exp_rdy, tag, in_ready, exp_rdy);
    if (exp_rdy) begin
      if (f >= 0 && !m_mask[f][lane]) begin
        m_mask[f][lane] = 1'b1; m_tid[f][lane] = TID_W'(tid);
      end else begin
        if (f >= 0) m_form[f] = 1'b0;
        slot = -1;
        for (int i = 0; i < MW; i++) if (slot < 0 && !m_vld[i]) slot = i;
        m_vld[slot] = 1'b1; m_form[slot] = 1'b1; m_pc[slot] = pc;
        m_mask[slot] = '0; m_mask[slot][lane] = 1'b1;
        for (int l = 0; l < LANES; l++) m_tid[slot][l] = '0;
        m_tid[slot][lane] = TID_W'(tid);
      end
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // called at the negedge after the cycle in which issue_req was high
  task automatic check_issue();
    int unsigned e; bit lockc; int ncl, got;
    if (n_warps() == 0) begin
      chk(out_valid == 1'b0, "R12", out_valid, 0);
      return;
    end
    lockc = m_lock_v && pc_count(m_lock_pc) > 0;
    e = lockc ? m_lock_pc : popular_pc();
    chk(out_valid == 1'b1, "R12", out_valid, 1);
    chk(out_pc == PC_W'(e), lockc ? "R9" : "R8", out_pc, e);
    ncl = 0;
    for (int i = 0; i < MW; i++) if (m_vld[i] && m_pc[i] == e && !m_form[i]) ncl++;
    got = -1;
    for (int i = 0; i < MW; i++)
      if (got < 0 && m_vld[i] && m_pc[i] == e && (m_form[i] == (ncl == 0)) && m_mask[i] == out_mask) begin
        bit same = 1'b1;
        for (int l = 0; l < LANES; l++)
          if (out_tids[l*TID_W +: TID_W] != m_tid[i][l]) same = 1'b0;
        if (same) got = i;
      end
    chk(got >= 0, "R2 R3 R10 warp content", out_mask, ncl);
    for (int l = 0; l < LANES; l++)
      if (!out_mask[l]) chk(out_tids[l*TID_W +: TID_W] == '0, "R12 idle lane", out_tids[l*TID_W +: TID_W], 0);
    if (got < 0)
      for (int i = 0; i < MW; i++) if (got < 0 && m_vld[i] && m_pc[i] == e) got = i;
    if (got >= 0) m_vld[got] = 1'b0;
    m_lock_v = 1'b1; m_lock_pc = e;
  endtask

  task automatic issue_one();
    @(negedge clk); issue_req = 1'b1;
    @(posedge clk);
    @(negedge clk); issue_req = 1'b0;
    check_issue();
  endtask

  task automatic drain();
    int guard = 0;
    while (n_warps() > 0 && guard < 64) begin issue_one(); guard++; end
    issue_one();
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < MW; i++) m_vld[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    rst_n = 1'b1;
    issue_one();                       // R1/R12: empty block issues nothing

    // R4 then R3: lane 3 twice, then lane 5 joins the second warp
    send(3, 'h100); send(11, 'h100); send(5, 'h100);
    drain();

    // R8 tie: one warp each, lower PC first
    send(1, 'h300); send(2, 'h200);
    drain();

    // R8 majority plus R9 lock
    send(0, 'h500); send(1, 'h480); send(8, 'h480); send(16, 'h480); send(9, 'h500);
    drain();

    // R6: nine distinct PCs against eight entries
    for (int k = 0; k < 9; k++) send(k, 'h400 + k);
    drain();

    // R7: seventeen threads for lane 0 at one PC against sixteen slots
    for (int k = 0; k < 17; k++) send(k * 8, 'h600);
    drain();

    // R11: forming warp issued while its PC arrives, then entry is free (R10)
    send(33, 'h55);
    @(negedge clk);
    issue_req = 1'b1; in_valid = 1'b1; in_tid = 8'd2; in_pc = 16'h55;
    #1 chk(in_ready == 1'b0, "R11", in_ready, 0);
    @(posedge clk);
    @(negedge clk);
    issue_req = 1'b0; in_valid = 1'b0;
    check_issue();
    send(2, 'h55);
    drain();

    // random rounds
    for (int r = 0; r < 12; r++) begin
      int n = 10 + int'($urandom % 20);
      for (int k = 0; k < n; k++)
        send($urandom % 256, 'h700 + ($urandom % 5) * 4);
      drain();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule